// File: doc/BRIEF.md
# Selectable-Strategy Branch Direction Predictor

This unit guesses whether a conditional branch in a simple in-order 32-bit pipeline will be taken. A two-bit mode input, held steady during operation, picks one of four policies: three static rules (always taken, never taken, and a rule based on the sign of the branch offset) and one dynamic rule driven by a table of two-bit saturating counters.

At fetch or decode the pipeline presents the branch address and its signed offset and reads back a combinational taken/not-taken guess. When the branch resolves, the pipeline pulses an update strobe with the branch address and the real outcome; in dynamic mode this trains the table. Mode code 00 selects the offset-sign rule, so a mode input tied to zero gives that rule after reset.

Top module: `bp_strategy_predictor`

## Requirements
- R1: Mode code 01 predicts taken for every branch, whatever the address and offset.
- R2: Mode code 10 predicts not taken for every branch, whatever the address and offset.
- R3: Mode code 00 (the tie-off default) predicts taken when the 32-bit two's complement offset is negative and not taken when it is zero or positive.
- R4: Mode code 11 predicts taken exactly when bit 1 of the counter selected by the prediction address is set (counter states 00 and 01 mean not taken, 10 and 11 mean taken).
- R5: The table holds 256 counters selected by address bits 9:2; addresses that differ only outside those bits share a counter, and after reset every counter holds 01, so dynamic mode predicts not taken.
- R6: An update strobe in mode 11 moves the selected counter one step up for a taken outcome and one step down for a not-taken outcome, stopping at 11 and at 00; the new value is visible from the next clock edge.
- R7: Update strobes while a static mode (00, 01, 10) is selected leave every counter unchanged.
- R8: When a prediction and an update select the same counter in the same cycle, the prediction uses the counter value from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Policy select: 00 offset sign, 01 taken, 10 not taken, 11 counters |
| pred_pc | input | 32 | Address of the branch being predicted |
| pred_offset | input | 32 | Signed branch offset of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | One-cycle strobe: a branch has resolved |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |

## Verification
On every cycle the assertions check the three static rules against the ports, that any counter write moves by exactly one step or holds at a limit, that writes occur only for a strobe in dynamic mode, and that a same-cycle read and write of one counter shows the old value first and the new one after the edge. Only the bench scenarios can show the reset value of the counters, the aliasing of addresses that share bits 9:2, a full training walk from weak not taken up to saturation and back down, and that strobes issued under a static mode leave nothing behind once dynamic mode is selected.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    BP_SIGN      = 2'b00,
    BP_TAKEN     = 2'b01,
    BP_NOT_TAKEN = 2'b10,
    BP_COUNTER   = 2'b11
  } bp_mode_e;

  localparam logic [1:0] CTR_RESET = 2'b01;

  // Saturating two-bit counter step.
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    if (taken) nxt = (cur == 2'b11) ? cur : cur + 2'd1;
    else       nxt = (cur == 2'b00) ? cur : cur - 2'd1;
    return nxt;
  endfunction

  // Offset-sign rule: backward (negative) target means taken.
  function automatic logic sign_rule(input logic offset_msb);
    return offset_msb;
  endfunction

endpackage

// File: rtl/bp_static_policy.sv
module bp_static_policy
  import bp_pkg::*;
#(
  parameter int OFF_W = 32
) (
  input  bp_mode_e           mode,
  input  logic [OFF_W-1:0]   offset,
  output logic               dir
);
  always_comb begin
    unique case (mode)
      BP_TAKEN:     dir = 1'b1;
      BP_NOT_TAKEN: dir = 1'b0;
      default:      dir = sign_rule(offset[OFF_W-1]);
    endcase
  end
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req,
  input  logic [PC_W-1:0] wr_pc,
  input  logic            wr_taken,
  input  logic [PC_W-1:0] rd_pc,
  output logic [1:0]      rd_ctr,
  output logic            wr_fire,
  output logic [1:0]      wr_old,
  output logic [1:0]      wr_new
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0]       ctr_q [DEPTH];
  logic [IDX_W-1:0] rd_idx, wr_idx;

  assign rd_idx  = rd_pc[IDX_W+1:2];
  assign wr_idx  = wr_pc[IDX_W+1:2];
  assign rd_ctr  = ctr_q[rd_idx];
  assign wr_fire = wr_req;
  assign wr_old  = ctr_q[wr_idx];
  assign wr_new  = ctr_step(wr_old, wr_taken);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_RESET;
    end else if (wr_fire) begin
      ctr_q[wr_idx] <= wr_new;
    end
  end
endmodule

// File: rtl/bp_strategy_predictor.sv
module bp_strategy_predictor
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_sel,
  input  logic [PC_W-1:0] pred_pc,
  input  logic [PC_W-1:0] pred_offset,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  bp_mode_e   mode;
  logic       static_dir;
  logic [1:0] rd_ctr;
  logic       upd_fire;
  logic       wr_fire;
  logic [1:0] wr_old, wr_new;

  assign mode     = bp_mode_e'(mode_sel);
  assign upd_fire = upd_valid && (mode == BP_COUNTER);

  bp_static_policy #(.OFF_W(PC_W)) static_i (
    .mode   (mode),
    .offset (pred_offset),
    .dir    (static_dir)
  );

  bp_counter_table #(.PC_W(PC_W), .IDX_W(IDX_W)) table_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (upd_fire),
    .wr_pc    (upd_pc),
    .wr_taken (upd_taken),
    .rd_pc    (pred_pc),
    .rd_ctr   (rd_ctr),
    .wr_fire  (wr_fire),
    .wr_old   (wr_old),
    .wr_new   (wr_new)
  );

  assign pred_taken = (mode == BP_COUNTER) ? rd_ctr[1] : static_dir;
endmodule

// File: rtl/bp_strategy_checker.sv
module bp_strategy_checker #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode_sel,
  input logic [PC_W-1:0] pred_pc,
  input logic [PC_W-1:0] pred_offset,
  input logic            pred_taken,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic            wr_fire,
  input logic [1:0]      wr_old,
  input logic [1:0]      wr_new
);
  logic same_entry;
  assign same_entry = pred_pc[IDX_W+1:2] == upd_pc[IDX_W+1:2];

  a_r1_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b01 |-> pred_taken);

  a_r2_never_taken: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b10 |-> !pred_taken);

  a_r3_sign_rule: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b00 |-> pred_taken == pred_offset[PC_W-1]);

  a_r6_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (upd_taken  && (wr_new == wr_old + 2'd1 || (wr_old == 2'b11 && wr_new == 2'b11))) ||
                (!upd_taken && (wr_new == wr_old - 2'd1 || (wr_old == 2'b00 && wr_new == 2'b00))));

  a_r7_no_static_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> mode_sel == 2'b11 && upd_valid);

  a_r8_old_then_new: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && same_entry) |-> pred_taken == wr_old[1]);

  a_r8_new_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && same_entry) ##1 ($stable(pred_pc) && mode_sel == 2'b11 && !$past(upd_valid && 1'b0))
      |-> pred_taken == $past(wr_new[1]));
endmodule

bind bp_strategy_predictor bp_strategy_checker #(.PC_W(PC_W), .IDX_W(IDX_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_sel    (mode_sel),
  .pred_pc     (pred_pc),
  .pred_offset (pred_offset),
  .pred_taken  (pred_taken),
  .upd_valid   (upd_valid),
  .upd_pc      (upd_pc),
  .upd_taken   (upd_taken),
  .wr_fire     (wr_fire),
  .wr_old      (wr_old),
  .wr_new      (wr_new)
);

// File: tb/bp_strategy_predictor_tb_top.sv
module bp_strategy_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [31:0] pred_pc = '0, pred_offset = '0, upd_pc = '0;
  logic        pred_taken, upd_valid = 1'b0, upd_taken = 1'b0;

  int checks = 0, errors = 0;
  int model [256];
  bit finished = 0;

  always #2.5 clk = ~clk;

  bp_strategy_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pred_pc(pred_pc),
    .pred_offset(pred_offset), .pred_taken(pred_taken), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  function automatic int idx_of(input logic [31:0] pc);
    return int'(pc[9:2]);
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: pred_taken=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic predict(input string req, input logic [31:0] pc, input logic [31:0] off, input logic exp);
    @(negedge clk);
    pred_pc = pc; pred_offset = off;
    #1 check(req, pred_taken, exp);
  endtask

  task automatic update(input logic [31:0] pc, input logic taken);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = taken;
    @(negedge clk);
    upd_valid = 1'b0;
    if (mode_sel == 2'b11) begin
      if (taken && model[idx_of(pc)] < 3) model[idx_of(pc)]++;
      if (!taken && model[idx_of(pc)] > 0) model[idx_of(pc)]--;
    end
  endtask

  task automatic t_reset_state;
    mode_sel = 2'b11;
    predict("R5 reset", 32'h0000_0000, 32'd0, 1'b0);
    predict("R5 reset", 32'h0000_03FC, 32'hFFFF_FFF0, 1'b0);
    predict("R4 reset", 32'h1234_5678, 32'd8, model[idx_of(32'h1234_5678)] >= 2);
  endtask

  task automatic t_static;
    mode_sel = 2'b01;
    predict("R1 taken pos", 32'h100, 32'd16, 1'b1);
    predict("R1 taken neg", 32'h104, 32'hFFFF_FF00, 1'b1);
    mode_sel = 2'b10;
    predict("R2 not taken neg", 32'h108, 32'hFFFF_FFFC, 1'b0);
    predict("R2 not taken pos", 32'h10C, 32'd4, 1'b0);
    mode_sel = 2'b00;
    predict("R3 negative", 32'h200, 32'hFFFF_FFF8, 1'b1);
    predict("R3 zero", 32'h204, 32'd0, 1'b0);
    predict("R3 positive", 32'h208, 32'd12, 1'b0);
    predict("R3 most negative", 32'h20C, 32'h8000_0000, 1'b1);
    predict("R3 most positive", 32'h210, 32'h7FFF_FFFF, 1'b0);
  endtask

  task automatic t_static_updates_ignored;
    mode_sel = 2'b01;
    update(32'h0000_0040, 1'b1);
    update(32'h0000_0040, 1'b1);
    mode_sel = 2'b00;
    update(32'h0000_0040, 1'b1);
    mode_sel = 2'b11;
    predict("R7 no train", 32'h0000_0040, 32'd0, 1'b0);
  endtask

  task automatic t_training;
    logic [31:0] pc = 32'h0000_0080;
    mode_sel = 2'b11;
    update(pc, 1'b1);
    predict("R6 01->10", pc, 32'd0, model[idx_of(pc)] >= 2);
    predict("R6 weak taken", pc, 32'd0, 1'b1);
    for (int i = 0; i < 4; i++) update(pc, 1'b1);
    update(pc, 1'b0);
    predict("R6 sat hi then 10", pc, 32'd0, 1'b1);
    update(pc, 1'b0);
    predict("R6 down to 01", pc, 32'd0, 1'b0);
    for (int i = 0; i < 4; i++) update(pc, 1'b0);
    update(pc, 1'b1);
    predict("R6 sat lo then 01", pc, 32'd0, 1'b0);
    update(pc, 1'b1);
    predict("R4 counter 10", pc, 32'hFFFF_FFFC, 1'b1);
  endtask

  task automatic t_aliasing;
    mode_sel = 2'b11;
    update(32'h0000_0010, 1'b1);
    predict("R5 alias bit10", 32'h0000_0410, 32'd0, 1'b1);
    predict("R5 alias low bits", 32'h0000_0013, 32'd0, 1'b1);
    predict("R5 neighbour", 32'h0000_0014, 32'd0, 1'b0);
    predict("R5 alias high", 32'hABCD_0010, 32'd0, model[idx_of(32'h10)] >= 2);
  endtask

  task automatic t_same_cycle;
    logic [31:0] pc = 32'h0000_0100;
    mode_sel = 2'b11;
    @(negedge clk);
    pred_pc = pc; upd_pc = pc; upd_valid = 1'b1; upd_taken = 1'b1;
    #1 check("R8 old value", pred_taken, 1'b0);
    @(negedge clk);
    upd_valid = 1'b0;
    model[idx_of(pc)] = 2;
    #1 check("R8 new value", pred_taken, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset_state();
    t_static();
    t_static_updates_ignored();
    t_training();
    t_aliasing();
    t_same_cycle();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule